// File: doc/BRIEF.md
# Stereo Serial Audio Slave Port

This block is the slave end of a two-channel serial audio link inside a codec. An external master supplies the bit clock (`bick`) and the frame clock (`lrck`). The port shifts 16-bit left and right capture samples out on `sdto` and assembles playback samples from `sdti` into parallel words. All three serial inputs pass through a synchronizer and are oversampled by the fast system clock `clk`. Every serial action is then taken on a detected edge of the bit clock, in the `clk` domain. The bit-clock half-period must exceed `SYNC_STAGES + 4` cycles of `clk`.

Two framing styles are available. In left-justified framing the frame clock level names the channel. In DSP framing a one-bit-wide frame pulse precedes a packed left-then-right word, and both the bit-clock edge used to launch data and the lead of the frame pulse can be configured. A disable input holds the serial output low. Configuration arrives on plain input ports. It is adopted only between frames, so that no word is ever split across two formats.

On the parallel side the port latches the next capture pair at each frame start and pulses `tx_taken`. It presents each received pair with a one-cycle `rx_valid` strobe.

Top module: `aud_serial_port`

## Requirements
- R1: During and right after reset, `sdto`, `rx_valid` and `tx_taken` are 0.
- R2: With `cfg_fmt` set to any code other than 2'b11 (the register reset code 2'b10 included), framing is left-justified. `lrck` high is the left slot and `lrck` low is the right slot. The MSB is driven after the first `bick` falling edge that follows each `lrck` transition. The 16 sample bits follow MSB first, one per falling edge, and `sdto` stays low for the remaining bit clocks of the slot.
- R3: In left-justified framing `sdti` is sampled on `bick` rising edges, 16 bits per slot, MSB first. Once the right LSB is in, the pair appears on `rx_left`/`rx_right` with a single-cycle `rx_valid` pulse.
- R4: With `cfg_fmt` = 2'b11 (DSP framing) and `cfg_edge_pol` = 0, `sdto` changes after `bick` rising edges and `sdti` is sampled on `bick` falling edges.
- R5: With DSP framing and `cfg_edge_pol` = 1, `sdto` changes after falling edges and `sdti` is sampled on rising edges.
- R6: With DSP framing and `cfg_pulse_lead` = 0, `lrck` is sampled on the data-sampling edge. A rise seen there is followed by the left MSB at the next launch edge, half a bit period later.
- R7: With DSP framing and `cfg_pulse_lead` = 1, `lrck` is sampled on launch edges, and the left MSB follows one full bit period after the rise. A pulse that rises half a period ahead of the launch edge is therefore taken one bit later.
- R8: In DSP framing the 16 right bits follow the left LSB directly (32 bits, left MSB first). `sdto` is low from then until the next frame, and received bits fill `rx_left` then `rx_right` in the same order.
- R9: While `sdo_disable` is 1, `sdto` is 0 from the next `clk` cycle on. Reception is not affected.
- R10: The capture pair `tx_left`/`tx_right` is sampled when a frame starts (start of the left slot), and `tx_taken` pulses for one cycle at that point. Later changes on those inputs do not alter the frame in flight.
- R11: `cfg_fmt`, `cfg_edge_pol` and `cfg_pulse_lead` are adopted only between frames, that is from the `rx_valid` pulse that completes a frame until the next frame start. A change made during a frame applies to the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial link |
| rst | input | 1 | Synchronous active-high reset |
| bick | input | 1 | Serial bit clock from the master |
| lrck | input | 1 | Frame / channel clock from the master |
| sdti | input | 1 | Serial playback data in |
| sdto | output | 1 | Serial capture data out (registered) |
| cfg_fmt | input | 2 | Framing code: 2'b11 DSP, anything else left-justified |
| cfg_edge_pol | input | 1 | DSP launch/sample edge pairing select |
| cfg_pulse_lead | input | 1 | DSP frame-pulse lead: 0 half period, 1 full period |
| sdo_disable | input | 1 | Forces `sdto` low when 1 |
| tx_left | input | SAMPLE_W | Left capture sample to transmit |
| tx_right | input | SAMPLE_W | Right capture sample to transmit |
| tx_taken | output | 1 | One-cycle pulse when the capture pair is latched |
| rx_left | output | SAMPLE_W | Received left playback sample |
| rx_right | output | SAMPLE_W | Received right playback sample |
| rx_valid | output | 1 | One-cycle strobe when a received pair is complete |

## Verification
The bench acts as the bus master. It runs frames in left-justified framing and in DSP framing with both edge pairings and both pulse leads, and each frame carries asymmetric bit patterns. Any swap of launch and sample edge therefore shows up as a one-bit shift of the words, as does any swap of channel order or MSB order.

One case drives the frame pulse with half-period timing while the full-period lead is selected. The expected words are then shifted by one bit, which separates the two lead settings. Other cases change the transmit words and the framing code in the middle of a frame, to show that the port latches at frame boundaries. A frame sent with the output disabled must give an all-zero `sdto` while its receive pair still arrives intact.

// File: rtl/aud_sport_pkg.sv
package aud_sport_pkg;

  // Framing codes; only 2'b11 selects the pulse-framed (DSP) format.
  localparam logic [1:0] FMT_LJ  = 2'b10;
  localparam logic [1:0] FMT_DSP = 2'b11;

  typedef struct packed {
    logic [1:0] fmt;
    logic       pol;    // DSP edge pairing
    logic       lead;   // DSP frame-pulse lead
  } port_cfg_t;

  localparam port_cfg_t CFG_RESET = '{fmt: FMT_LJ, pol: 1'b0, lead: 1'b0};

endpackage

// File: rtl/aud_sport_sync.sv
module aud_sport_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/aud_sport_framer.sv
module aud_sport_framer import aud_sport_pkg::*; (
  input  logic      clk,
  input  logic      rst,
  input  logic      bick_s,
  input  logic      lrck_s,
  input  port_cfg_t cfg_in,
  input  logic      rx_done,
  output logic      launch,
  output logic      capture,
  output logic      frame_start,
  output logic      right_start,
  output logic      dsp_mode
);

  port_cfg_t cfg_q;
  logic bick_q, lr_prev_q, armed_q, idle_q;
  logic rise, fall, lr_edge, lr_changed;

  assign rise     = bick_s & ~bick_q;
  assign fall     = ~bick_s & bick_q;
  assign dsp_mode = (cfg_q.fmt == FMT_DSP);
  assign launch   = dsp_mode ? (cfg_q.pol ? fall : rise) : fall;
  assign capture  = dsp_mode ? (cfg_q.pol ? rise : fall) : rise;

  // Edge on which the frame clock is looked at.
  assign lr_edge    = dsp_mode ? (cfg_q.lead ? launch : capture) : launch;
  assign lr_changed = lr_edge && (lrck_s != lr_prev_q);

  assign frame_start = dsp_mode ? (launch && armed_q) : (lr_changed && lrck_s);
  assign right_start = !dsp_mode && lr_changed && !lrck_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= CFG_RESET;
      bick_q    <= 1'b0;
      lr_prev_q <= 1'b0;
      armed_q   <= 1'b0;
      idle_q    <= 1'b1;
    end else begin
      bick_q <= bick_s;
      if (lr_edge) lr_prev_q <= lrck_s;

      if (!dsp_mode || frame_start) armed_q <= 1'b0;
      if (dsp_mode && lr_changed && lrck_s) armed_q <= 1'b1;

      if (frame_start)  idle_q <= 1'b0;
      else if (rx_done) idle_q <= 1'b1;

      if (idle_q && !frame_start) cfg_q <= cfg_in;
    end
  end

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !idle_q |=> $stable(cfg_q));

endmodule

// File: rtl/aud_sport_tx.sv
module aud_sport_tx #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         launch,
  input  logic         frame_start,
  input  logic         right_start,
  input  logic         dsp_mode,
  input  logic         sdo_dis,
  input  logic [W-1:0] tx_left,
  input  logic [W-1:0] tx_right,
  output logic         tx_taken,
  output logic         sdto
);

  localparam int CW = $clog2(2*W+1);
  localparam logic [CW-1:0] HALF = CW'(W);
  localparam logic [CW-1:0] FULL = CW'(2*W);

  logic [W-1:0]  sh_q, rhold_q;
  logic [CW-1:0] cnt_q;
  logic          bit_q, taken_q, sdto_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      rhold_q <= '0;
      cnt_q   <= '0;
      bit_q   <= 1'b0;
      taken_q <= 1'b0;
      sdto_q  <= 1'b0;
    end else begin
      taken_q <= 1'b0;
      sdto_q  <= bit_q & ~sdo_dis;
      if (launch) begin
        if (frame_start) begin
          bit_q   <= tx_left[W-1];
          sh_q    <= {tx_left[W-2:0], 1'b0};
          rhold_q <= tx_right;
          cnt_q   <= CW'(1);
          taken_q <= 1'b1;
        end else if (right_start || (dsp_mode && cnt_q == HALF)) begin
          bit_q <= rhold_q[W-1];
          sh_q  <= {rhold_q[W-2:0], 1'b0};
          cnt_q <= HALF + CW'(1);
        end else if (cnt_q != '0 && cnt_q < FULL && cnt_q != HALF) begin
          bit_q <= sh_q[W-1];
          sh_q  <= {sh_q[W-2:0], 1'b0};
          cnt_q <= cnt_q + CW'(1);
        end else begin
          bit_q <= 1'b0;
        end
      end
    end
  end

  assign tx_taken = taken_q;
  assign sdto     = sdto_q;

  // R10
  taken_on_launch_chk: assert property (@(posedge clk) disable iff (rst)
    tx_taken |-> $past(launch));

endmodule

// File: rtl/aud_sport_rx.sv
module aud_sport_rx #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         capture,
  input  logic         frame_start,
  input  logic         right_start,
  input  logic         dsp_mode,
  input  logic         sdti_s,
  output logic [W-1:0] rx_left,
  output logic [W-1:0] rx_right,
  output logic         rx_valid
);

  localparam int CW = $clog2(2*W+1);
  localparam logic [CW-1:0] HALF = CW'(W);
  localparam logic [CW-1:0] FULL = CW'(2*W);

  logic [2*W-1:0] sh_q, nxt;
  logic [CW-1:0]  cnt_q;
  logic           rgo_q, valid_q;
  logic [W-1:0]   left_q, right_q;

  assign nxt = {sh_q[2*W-2:0], sdti_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      cnt_q   <= FULL;
      rgo_q   <= 1'b0;
      valid_q <= 1'b0;
      left_q  <= '0;
      right_q <= '0;
    end else begin
      valid_q <= 1'b0;
      if (frame_start) begin
        cnt_q <= '0;
        rgo_q <= 1'b0;
      end else if (right_start) begin
        if (cnt_q == HALF) rgo_q <= 1'b1;
        else               cnt_q <= FULL;
      end else if (capture && cnt_q < FULL &&
                   (dsp_mode || cnt_q != HALF || rgo_q)) begin
        sh_q  <= nxt;
        cnt_q <= cnt_q + CW'(1);
        if (cnt_q == FULL - CW'(1)) begin
          left_q  <= nxt[2*W-1:W];
          right_q <= nxt[W-1:0];
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign rx_left  = left_q;
  assign rx_right = right_q;
  assign rx_valid = valid_q;

  // R3
  valid_on_capture_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(capture));

endmodule

// File: rtl/aud_serial_port.sv
module aud_serial_port import aud_sport_pkg::*; #(
  parameter int SAMPLE_W    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bick,
  input  logic                lrck,
  input  logic                sdti,
  output logic                sdto,
  input  logic [1:0]          cfg_fmt,
  input  logic                cfg_edge_pol,
  input  logic                cfg_pulse_lead,
  input  logic                sdo_disable,
  input  logic [SAMPLE_W-1:0] tx_left,
  input  logic [SAMPLE_W-1:0] tx_right,
  output logic                tx_taken,
  output logic [SAMPLE_W-1:0] rx_left,
  output logic [SAMPLE_W-1:0] rx_right,
  output logic                rx_valid
);

  logic [2:0] ser_s;
  logic       launch, capture, frame_start, right_start, dsp_mode;
  port_cfg_t  cfg_in;

  assign cfg_in = '{fmt: cfg_fmt, pol: cfg_edge_pol, lead: cfg_pulse_lead};

  aud_sport_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({bick, lrck, sdti}),
    .q   (ser_s)
  );

  aud_sport_framer u_framer (
    .clk         (clk),
    .rst         (rst),
    .bick_s      (ser_s[2]),
    .lrck_s      (ser_s[1]),
    .cfg_in      (cfg_in),
    .rx_done     (rx_valid),
    .launch      (launch),
    .capture     (capture),
    .frame_start (frame_start),
    .right_start (right_start),
    .dsp_mode    (dsp_mode)
  );

  aud_sport_tx #(.W(SAMPLE_W)) u_tx (
    .clk         (clk),
    .rst         (rst),
    .launch      (launch),
    .frame_start (frame_start),
    .right_start (right_start),
    .dsp_mode    (dsp_mode),
    .sdo_dis     (sdo_disable),
    .tx_left     (tx_left),
    .tx_right    (tx_right),
    .tx_taken    (tx_taken),
    .sdto        (sdto)
  );

  aud_sport_rx #(.W(SAMPLE_W)) u_rx (
    .clk         (clk),
    .rst         (rst),
    .capture     (capture),
    .frame_start (frame_start),
    .right_start (right_start),
    .dsp_mode    (dsp_mode),
    .sdti_s      (ser_s[0]),
    .rx_left     (rx_left),
    .rx_right    (rx_right),
    .rx_valid    (rx_valid)
  );

  // R9
  dis_low_chk: assert property (@(posedge clk) disable iff (rst)
    sdo_disable |=> !sdto);

endmodule

// File: tb/tb_aud_serial_port.sv
module tb_aud_serial_port;
  localparam int W    = 16;
  localparam int H    = 8;    // bick half period in clk cycles
  localparam int NB   = 40;   // bit periods per DSP frame
  localparam int SLOT = 20;   // bit periods per LJ slot

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, bick, lrck, sdti, sdo_disable, cfg_edge_pol, cfg_pulse_lead;
  logic [1:0] cfg_fmt;
  logic [W-1:0] tx_left, tx_right, rx_left, rx_right;
  logic sdto, tx_taken, rx_valid;

  aud_serial_port #(.SAMPLE_W(W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .bick(bick), .lrck(lrck), .sdti(sdti), .sdto(sdto),
    .cfg_fmt(cfg_fmt), .cfg_edge_pol(cfg_edge_pol), .cfg_pulse_lead(cfg_pulse_lead),
    .sdo_disable(sdo_disable), .tx_left(tx_left), .tx_right(tx_right),
    .tx_taken(tx_taken), .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
  );

  int checks = 0, fails = 0, vcount = 0, tcount = 0;
  logic [W-1:0] vl, vr;
  logic [NB-1:0] rec;
  logic [2*SLOT-1:0] rec_lj;

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin vcount++; vl = rx_left; vr = rx_right; end
      if (tx_taken) tcount++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] dsp_exp(input logic [31:0] w, input int sh);
    logic [NB-1:0] e;
    for (int p = 0; p < NB; p++) begin
      int k = p - sh;
      e[p] = (k >= 0 && k < 32) ? w[31-k] : 1'b0;
    end
    return e;
  endfunction

  function automatic logic [2*SLOT-1:0] lj_exp(input logic [W-1:0] l, input logic [W-1:0] r);
    logic [2*SLOT-1:0] e;
    for (int i = 0; i < SLOT; i++) begin
      e[i]        = (i < W) ? l[W-1-i] : 1'b0;
      e[SLOT + i] = (i < W) ? r[W-1-i] : 1'b0;
    end
    return e;
  endfunction

  // Master for DSP framing; mph = 1 drives the pulse a full period ahead.
  task automatic dsp_frame(input logic pol, input logic mph, input logic [31:0] m,
                           input int chg_at, input logic [1:0] chg_fmt);
    bick = pol; lrck = 1'b0; sdti = 1'b0;
    tick(2*H);
    for (int p = -1; p < NB; p++) begin
      bick = ~bick;
      if (mph) lrck = (p == -1);
      sdti = (p >= 0 && p < 32) ? m[31-p] : 1'b0;
      if (p == chg_at) cfg_fmt = chg_fmt;
      tick(H-1);
      if (p >= 0) rec[p] = sdto;
      tick(1);
      bick = ~bick;
      if (!mph) lrck = (p == -1);
      tick(H);
    end
    lrck = 1'b0; sdti = 1'b0;
    tick(2*H);
  endtask

  task automatic lj_frame(input logic [W-1:0] ml, input logic [W-1:0] mr, input int chg_bit,
                          input logic [W-1:0] nl, input logic [W-1:0] nr);
    bick = 1'b1; sdti = 1'b0;
    tick(2*H);
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < SLOT; i++) begin
        bick = 1'b0;
        if (i == 0) lrck = (s == 0);
        sdti = (i < W) ? ((s == 0) ? ml[W-1-i] : mr[W-1-i]) : 1'b0;
        if (s == 0 && i == chg_bit) begin tx_left = nl; tx_right = nr; end
        tick(H-1);
        rec_lj[s*SLOT + i] = sdto;
        tick(1);
        bick = 1'b1;
        tick(H);
      end
    end
    sdti = 1'b0;
    tick(2*H);
  endtask

  task automatic set_cfg(input logic [1:0] f, input logic p, input logic l);
    cfg_fmt = f; cfg_edge_pol = p; cfg_pulse_lead = l;
    tick(4);
  endtask

  task automatic t_reset();
    rst = 1'b1; bick = 1'b1; lrck = 1'b0; sdti = 1'b0; sdo_disable = 1'b0;
    cfg_fmt = 2'b10; cfg_edge_pol = 1'b0; cfg_pulse_lead = 1'b0;
    tx_left = '0; tx_right = '0;
    tick(6);
    chk("R1 sdto in reset", sdto, 0);
    rst = 1'b0;
    tick(3);
    chk("R1 sdto after reset", sdto, 0);
    chk("R1 rx_valid after reset", rx_valid, 0);
    chk("R1 tx_taken after reset", tx_taken, 0);
  endtask

  task automatic t_lj();
    int v0, t0;
    set_cfg(2'b10, 1'b0, 1'b0);
    tx_left = 16'hA5C3; tx_right = 16'h3C96;
    v0 = vcount; t0 = tcount;
    lj_frame(16'h1234, 16'hFEDC, -1, '0, '0);
    chk("R2 LJ transmit slots", rec_lj, lj_exp(16'hA5C3, 16'h3C96));
    chk("R3 LJ rx_valid count", vcount - v0, 1);
    chk("R3 LJ received pair", {vl, vr}, {16'h1234, 16'hFEDC});
    chk("R10 tx_taken per frame", tcount - t0, 1);
    // R10: new words presented mid-frame must not disturb this frame
    tx_left = 16'h8001; tx_right = 16'h7FFE;
    lj_frame(16'h0F0F, 16'hC001, 3, 16'h5555, 16'hAAAA);
    chk("R10 held pair during frame", rec_lj, lj_exp(16'h8001, 16'h7FFE));
    chk("R3 LJ second pair", {vl, vr}, {16'h0F0F, 16'hC001});
    lj_frame(16'h0000, 16'h0001, -1, '0, '0);
    chk("R10 new pair next frame", rec_lj, lj_exp(16'h5555, 16'hAAAA));
  endtask

  task automatic t_dsp(input string req, input logic pol, input logic lead, input logic mph,
                       input int shift);
    int v0;
    logic [31:0] m;
    set_cfg(2'b11, pol, lead);
    tx_left = 16'hC35A; tx_right = 16'h0F81;
    m = {16'hB2E1, 16'h4D17};
    v0 = vcount;
    dsp_frame(pol, mph, m, -2, 2'b11);
    chk({req, " DSP transmit word"}, rec, dsp_exp({16'hC35A, 16'h0F81}, shift));
    chk({req, " DSP rx_valid count"}, vcount - v0, 1);
    chk({req, " DSP received pair"}, {vl, vr}, (shift == 0) ? m : {m[30:0], 1'b0});
  endtask

  task automatic t_disable();
    int v0;
    set_cfg(2'b11, 1'b0, 1'b0);
    tx_left = 16'hFFFF; tx_right = 16'hF00F;
    sdo_disable = 1'b1;
    v0 = vcount;
    dsp_frame(1'b0, 1'b0, 32'h96A5_3C01, -2, 2'b11);
    chk("R9 output held low", rec, '0);
    chk("R9 receive unaffected", {vl, vr}, 32'h96A5_3C01);
    chk("R9 rx_valid count", vcount - v0, 1);
    sdo_disable = 1'b0;
    tick(4);
  endtask

  task automatic t_fmt_change();
    set_cfg(2'b11, 1'b0, 1'b0);
    tx_left = 16'h9E37; tx_right = 16'h61C8;
    dsp_frame(1'b0, 1'b0, 32'h1357_9BDF, 5, 2'b10);
    chk("R11 frame kept old format", rec, dsp_exp({16'h9E37, 16'h61C8}, 0));
    chk("R11 rx pair kept old format", {vl, vr}, 32'h1357_9BDF);
    tx_left = 16'h2468; tx_right = 16'hACE0;
    lj_frame(16'h7531, 16'h0ECA, -1, '0, '0);
    chk("R11 new format next frame", rec_lj, lj_exp(16'h2468, 16'hACE0));
    chk("R11 LJ rx after change", {vl, vr}, {16'h7531, 16'h0ECA});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    t_reset();
    t_lj();
    t_dsp("R4 R6 R8 pol0 lead0", 1'b0, 1'b0, 1'b0, 0);
    t_dsp("R5 pol1 lead0", 1'b1, 1'b0, 1'b0, 0);
    t_dsp("R7 pol1 lead1", 1'b1, 1'b1, 1'b1, 0);
    t_dsp("R7 lead1 with half-period pulse", 1'b0, 1'b1, 1'b0, 1);
    t_disable();
    t_fmt_change();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule